// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Resolver

This block sits beside a floating-point datapath. It turns the raw exception conditions of a finished operation into the architectural status fields. The conditions are invalid, divide-by-zero, overflow, tininess and result exactness. The block applies the trap-enable mask to them and produces three things: the current-exception field, the accrued-exception field and the trap-type field. When an enabled exception must be delivered, it also raises a one-cycle trap request. Tininess is taken as detected before rounding, so the datapath reports it from the exact unrounded result.

An operation-complete strobe loads a new resolution into the status fields. A conditional-move strobe clears the current-exception and trap-type fields, whatever the outcome of the move condition. Trap vectoring and the arithmetic itself live elsewhere.

Top module: `fpx_flag_resolver`

## Requirements
- R1: A synchronous active-high reset clears the current, accrued and trap-type fields to zero and holds the trap output low. Flag bit positions in the current, accrued and mask fields are: invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0.
- R2: Overflow with both the overflow and inexact masks clear sets the overflow and inexact current bits, clears the rest and raises no trap. Overflow always counts as inexact, whatever the exactness input says.
- R3: Overflow with the overflow mask set reports only the overflow current bit and traps, whatever the inexact mask is.
- R4: Overflow with the overflow mask clear and the inexact mask set reports only the inexact current bit and traps.
- R5: A tiny result with the underflow mask set reports only the underflow current bit and traps, even when the rounded result is exact.
- R6: A tiny but exact result with the underflow mask clear sets no current bit and raises no trap.
- R7: A tiny inexact result with the underflow mask clear sets the underflow and inexact bits with no trap when the inexact mask is clear. When the inexact mask is set, it reports inexact only and traps.
- R8: An inexact result with no other condition sets only the inexact current bit. It traps exactly when the inexact mask is set.
- R9: Invalid or divide-by-zero outranks every other condition. Only those two bits are reported, and a trap is raised when the mask bit of a present one is set.
- R10: When an operation completes without a trap, its current bits are ORed into the accrued field and the trap-type field becomes 0. When it traps, the accrued field is left unchanged and the trap-type field becomes 1, the IEEE-exception code.
- R11: The trap output rises in the cycle after the completing operation's strobe edge and lasts exactly one cycle per strobe.
- R12: A conditional-move strobe clears the current and trap-type fields and leaves the accrued field unchanged. If it coincides with an operation strobe, the move wins: the operation is dropped and no trap is raised.
- R13: With neither strobe asserted, all status fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation-complete strobe |
| fmov_i | input | 1 | Conditional floating-point move strobe |
| nv_i | input | 1 | Invalid operation detected |
| dz_i | input | 1 | Divide-by-zero detected |
| of_i | input | 1 | Overflow detected |
| tiny_i | input | 1 | Tininess detected before rounding |
| exact_i | input | 1 | Rounded result equals exact result |
| trap_mask_i | input | 5 | Trap-enable mask (bit order as in R1) |
| cexc_o | output | 5 | Current-exception field |
| aexc_o | output | 5 | Accrued-exception field |
| ftt_o | output | 3 | Trap-type field |
| trap_o | output | 1 | One-cycle trap request |

## Verification
A conditional move and a completing operation can land in the same cycle. The bench provokes this by raising both strobes together on an operation whose masks would otherwise trap on overflow. It then judges the result: the current and trap-type fields must be zero, no trap pulse may appear, and the accrued field must keep the value it had before. This shows that the move clears the fields, that the dropped operation leaves no side effect, and that the trap path is fenced off by the move.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   localparam int FLAG_W  = 5;
   localparam int IDX_NX  = 0;
   localparam int IDX_DZ  = 1;
   localparam int IDX_UF  = 2;
   localparam int IDX_OF  = 3;
   localparam int IDX_NV  = 4;
   typedef logic [FLAG_W-1:0] flag_t;

   typedef struct packed {
      logic nv;
      logic dz;
      logic of;
      logic tiny;
      logic exact;
   } raw_cond_t;
endpackage

// File: rtl/fpx_resolve.sv
// Combinational priority resolution of raw conditions against the trap mask.
module fpx_resolve
   import fpx_pkg::*;
(
   input  raw_cond_t cond_i,
   input  flag_t     mask_i,
   output flag_t     cexc_o,
   output logic      trap_o
);
   logic inexact;

   // overflow implies an inexact result regardless of the exactness input
   assign inexact = !cond_i.exact || cond_i.of;

   always_comb begin
      cexc_o = '0;
      trap_o = 1'b0;
      if (cond_i.nv || cond_i.dz) begin
         cexc_o[IDX_NV] = cond_i.nv;
         cexc_o[IDX_DZ] = cond_i.dz;
         trap_o = (cond_i.nv && mask_i[IDX_NV]) || (cond_i.dz && mask_i[IDX_DZ]);
      end else if (cond_i.of) begin
         if (mask_i[IDX_OF]) begin
            cexc_o[IDX_OF] = 1'b1;
            trap_o = 1'b1;
         end else if (mask_i[IDX_NX]) begin
            cexc_o[IDX_NX] = 1'b1;
            trap_o = 1'b1;
         end else begin
            cexc_o[IDX_OF] = 1'b1;
            cexc_o[IDX_NX] = 1'b1;
         end
      end else if (cond_i.tiny) begin
         if (mask_i[IDX_UF]) begin
            cexc_o[IDX_UF] = 1'b1;
            trap_o = 1'b1;
         end else if (inexact) begin
            if (mask_i[IDX_NX]) begin
               cexc_o[IDX_NX] = 1'b1;
               trap_o = 1'b1;
            end else begin
               cexc_o[IDX_UF] = 1'b1;
               cexc_o[IDX_NX] = 1'b1;
            end
         end
      end else if (inexact) begin
         cexc_o[IDX_NX] = 1'b1;
         trap_o = mask_i[IDX_NX];
      end
   end
endmodule

// File: rtl/fpx_status.sv
// Status field registers: current, accrued, trap type and trap pulse.
module fpx_status #(
   parameter int FLAG_W   = 5,
   parameter int FTT_W    = 3,
   parameter int FTT_IEEE = 1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              op_valid_i,
   input  logic              fmov_i,
   input  logic [FLAG_W-1:0] cexc_next_i,
   input  logic              trap_req_i,
   output logic [FLAG_W-1:0] cexc_o,
   output logic [FLAG_W-1:0] aexc_o,
   output logic [FTT_W-1:0]  ftt_o,
   output logic              trap_o
);
   localparam logic [FTT_W-1:0] FTT_CODE = FTT_W'(FTT_IEEE);

   logic take_op;
   logic accrue;

   assign take_op = op_valid_i && !fmov_i;
   assign accrue  = take_op && !trap_req_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cexc_o <= '0;
         ftt_o  <= '0;
         trap_o <= 1'b0;
      end else if (fmov_i) begin
         cexc_o <= '0;
         ftt_o  <= '0;
         trap_o <= 1'b0;
      end else if (op_valid_i) begin
         cexc_o <= cexc_next_i;
         ftt_o  <= trap_req_i ? FTT_CODE : '0;
         trap_o <= trap_req_i;
      end else begin
         trap_o <= 1'b0;
      end
   end

   for (genvar b = 0; b < FLAG_W; b++) begin : g_accrue
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            aexc_o[b] <= 1'b0;
         end else if (accrue && cexc_next_i[b]) begin
            aexc_o[b] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/fpx_flag_resolver.sv
module fpx_flag_resolver
   import fpx_pkg::*;
#(
   parameter int FTT_W    = 3,
   parameter int FTT_IEEE = 1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              op_valid_i,
   input  logic              fmov_i,
   input  logic              nv_i,
   input  logic              dz_i,
   input  logic              of_i,
   input  logic              tiny_i,
   input  logic              exact_i,
   input  logic [FLAG_W-1:0] trap_mask_i,
   output logic [FLAG_W-1:0] cexc_o,
   output logic [FLAG_W-1:0] aexc_o,
   output logic [FTT_W-1:0]  ftt_o,
   output logic              trap_o
);
   if (FTT_W < 1 || FTT_W > 8) begin : g_bad_ftt_w
      $error("fpx_flag_resolver: FTT_W out of range");
   end
   if (FTT_IEEE < 1 || FTT_IEEE >= (1 << FTT_W)) begin : g_bad_ftt_code
      $error("fpx_flag_resolver: FTT_IEEE does not fit FTT_W");
   end

   raw_cond_t cond;
   flag_t     cexc_next;
   logic      trap_req;

   assign cond = '{nv: nv_i, dz: dz_i, of: of_i, tiny: tiny_i, exact: exact_i};

   fpx_resolve u_resolve (
      .cond_i (cond),
      .mask_i (trap_mask_i),
      .cexc_o (cexc_next),
      .trap_o (trap_req)
   );

   fpx_status #(
      .FLAG_W   (FLAG_W),
      .FTT_W    (FTT_W),
      .FTT_IEEE (FTT_IEEE)
   ) u_status (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .op_valid_i  (op_valid_i),
      .fmov_i      (fmov_i),
      .cexc_next_i (cexc_next),
      .trap_req_i  (trap_req),
      .cexc_o      (cexc_o),
      .aexc_o      (aexc_o),
      .ftt_o       (ftt_o),
      .trap_o      (trap_o)
   );
endmodule

// File: rtl/fpx_flag_resolver_chk.sv
module fpx_flag_resolver_chk #(
   parameter int FTT_W    = 3,
   parameter int FTT_IEEE = 1
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             op_valid_i,
   input logic             fmov_i,
   input logic             nv_i,
   input logic             dz_i,
   input logic             of_i,
   input logic [4:0]       trap_mask_i,
   input logic [4:0]       cexc_o,
   input logic [4:0]       aexc_o,
   input logic [FTT_W-1:0] ftt_o,
   input logic             trap_o
);
   assert_trap_source_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      trap_o |-> ($past(op_valid_i) && !$past(fmov_i)));

   assert_trap_keeps_accrued_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      trap_o |-> ($stable(aexc_o) && ftt_o == FTT_W'(FTT_IEEE)));

   assert_fmov_clears_R12: assert property (@(posedge clk_i) disable iff (rst_i)
      fmov_i |=> (cexc_o == 5'b0 && ftt_o == '0 && !trap_o && $stable(aexc_o)));

   assert_idle_holds_R13: assert property (@(posedge clk_i) disable iff (rst_i)
      (!op_valid_i && !fmov_i) |=> ($stable(cexc_o) && $stable(aexc_o) && $stable(ftt_o)));

   assert_overflow_trapped_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (op_valid_i && !fmov_i && of_i && !nv_i && !dz_i && trap_mask_i[3])
      |=> (cexc_o == 5'b01000 && trap_o));
endmodule

bind fpx_flag_resolver fpx_flag_resolver_chk #(.FTT_W(FTT_W), .FTT_IEEE(FTT_IEEE)) u_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .op_valid_i  (op_valid_i),
   .fmov_i      (fmov_i),
   .nv_i        (nv_i),
   .dz_i        (dz_i),
   .of_i        (of_i),
   .trap_mask_i (trap_mask_i),
   .cexc_o      (cexc_o),
   .aexc_o      (aexc_o),
   .ftt_o       (ftt_o),
   .trap_o      (trap_o)
);

// File: tb/fpx_flag_resolver_tb_top.sv
module fpx_flag_resolver_tb_top;
   logic       clk = 1'b0;
   logic       rst;
   logic       op_valid, fmov;
   logic       nv, dz, of, tiny, exact;
   logic [4:0] mask;
   logic [4:0] cexc, aexc;
   logic [2:0] ftt;
   logic       trap;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   logic [4:0] exp_aexc = '0;

   always #2 clk = ~clk;

   fpx_flag_resolver dut_i (
      .clk_i (clk), .rst_i (rst), .op_valid_i (op_valid), .fmov_i (fmov),
      .nv_i (nv), .dz_i (dz), .of_i (of), .tiny_i (tiny), .exact_i (exact),
      .trap_mask_i (mask), .cexc_o (cexc), .aexc_o (aexc), .ftt_o (ftt), .trap_o (trap)
   );

   // {nv,dz,of,tiny,exact}, mask {nv,of,uf,dz,nx}, expected cexc, expected trap
   localparam int NV = 17;
   localparam logic [15:0] VEC [NV] = '{
      {5'b00100, 5'b00000, 5'b01001, 1'b0},  // R2
      {5'b00100, 5'b01000, 5'b01000, 1'b1},  // R3
      {5'b00101, 5'b01001, 5'b01000, 1'b1},  // R3 (exact input ignored)
      {5'b00100, 5'b00001, 5'b00001, 1'b1},  // R4
      {5'b00011, 5'b00100, 5'b00100, 1'b1},  // R5 exact
      {5'b00010, 5'b00101, 5'b00100, 1'b1},  // R5 inexact
      {5'b00011, 5'b00000, 5'b00000, 1'b0},  // R6
      {5'b00011, 5'b00001, 5'b00000, 1'b0},  // R6
      {5'b00010, 5'b00000, 5'b00101, 1'b0},  // R7
      {5'b00010, 5'b00001, 5'b00001, 1'b1},  // R7
      {5'b00000, 5'b00000, 5'b00001, 1'b0},  // R8
      {5'b00000, 5'b00001, 5'b00001, 1'b1},  // R8
      {5'b10100, 5'b00000, 5'b10000, 1'b0},  // R9
      {5'b10001, 5'b10000, 5'b10000, 1'b1},  // R9
      {5'b01000, 5'b00001, 5'b00010, 1'b0},  // R9
      {5'b01001, 5'b00010, 5'b00010, 1'b1},  // R9
      {5'b00001, 5'b11111, 5'b00000, 1'b0}   // R8 nothing raised
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [4:0] c, input logic [4:0] m, input logic ov, input logic mv);
      {nv, dz, of, tiny, exact} = c;
      mask = m; op_valid = ov; fmov = mv;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      drive(5'b00001, 5'b0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 cexc", {3'b0, cexc}, 8'h00);
      chk("R1 aexc", {3'b0, aexc}, 8'h00);
      chk("R1 ftt",  {5'b0, ftt},  8'h00);
      chk("R1 trap", {7'b0, trap}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         logic [15:0] v;
         logic [4:0]  prev_c;
         logic [2:0]  prev_f;
         v = VEC[i];
         drive(v[15:11], v[10:6], 1'b1, 1'b0);
         @(negedge clk);
         drive(5'b00001, 5'b0, 1'b0, 1'b0);
         if (!v[0]) exp_aexc = exp_aexc | v[5:1];
         chk($sformatf("R%0s vec%0d cexc", "2-9", i), {3'b0, cexc}, {3'b0, v[5:1]});
         chk($sformatf("R11 vec%0d trap", i), {7'b0, trap}, {7'b0, v[0]});
         chk($sformatf("R10 vec%0d ftt", i), {5'b0, ftt}, v[0] ? 8'h01 : 8'h00);
         chk($sformatf("R10 vec%0d aexc", i), {3'b0, aexc}, {3'b0, exp_aexc});
         prev_c = cexc; prev_f = ftt;
         @(negedge clk);
         chk($sformatf("R11 vec%0d trap drop", i), {7'b0, trap}, 8'h00);
         chk($sformatf("R13 vec%0d cexc hold", i), {3'b0, cexc}, {3'b0, prev_c});
         chk($sformatf("R13 vec%0d ftt hold", i), {5'b0, ftt}, {5'b0, prev_f});
      end

      // R12: trap leaves ftt=1; a move clears cexc and ftt, keeps aexc
      drive(5'b00100, 5'b01000, 1'b1, 1'b0);
      @(negedge clk);
      chk("R3 pre-move ftt", {5'b0, ftt}, 8'h01);
      drive(5'b00001, 5'b0, 1'b0, 1'b1);
      @(negedge clk);
      drive(5'b00001, 5'b0, 1'b0, 1'b0);
      chk("R12 move cexc", {3'b0, cexc}, 8'h00);
      chk("R12 move ftt",  {5'b0, ftt},  8'h00);
      chk("R12 move aexc", {3'b0, aexc}, {3'b0, exp_aexc});

      // R12: move coincident with a trapping operation
      drive(5'b00010, 5'b00000, 1'b1, 1'b0);
      @(negedge clk);
      exp_aexc = exp_aexc | 5'b00101;
      drive(5'b00100, 5'b01000, 1'b1, 1'b1);
      @(negedge clk);
      drive(5'b00001, 5'b0, 1'b0, 1'b0);
      chk("R12 both cexc", {3'b0, cexc}, 8'h00);
      chk("R12 both ftt",  {5'b0, ftt},  8'h00);
      chk("R12 both trap", {7'b0, trap}, 8'h00);
      chk("R12 both aexc", {3'b0, aexc}, {3'b0, exp_aexc});

      // R11: back-to-back trapping operations give one pulse each
      drive(5'b00000, 5'b00001, 1'b1, 1'b0);
      @(negedge clk);
      chk("R11 b2b first", {7'b0, trap}, 8'h01);
      @(negedge clk);
      drive(5'b00001, 5'b0, 1'b0, 1'b0);
      chk("R11 b2b second", {7'b0, trap}, 8'h01);
      @(negedge clk);
      chk("R11 b2b end", {7'b0, trap}, 8'h00);
      chk("R10 b2b aexc", {3'b0, aexc}, {3'b0, exp_aexc});

      // R1: reset mid-run clears everything
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 rerun cexc", {3'b0, cexc}, 8'h00);
      chk("R1 rerun aexc", {3'b0, aexc}, 8'h00);
      chk("R1 rerun ftt",  {5'b0, ftt},  8'h00);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule